// File: doc/BRIEF.md
# Fractional UART baud-rate generator

This block derives the 16x oversampling enable for a UART receiver and transmitter from the peripheral clock. A 16-bit integer divisor sets the base period of the enable pulse. A fractional prescaler, programmed with a 4-bit multiplier and a 4-bit addend, stretches selected periods so that the average rate is `clk / (16 * divisor * (1 + addend / multiplier))`. This lets a small divisor hit standard baud rates with far less error than a plain integer divider. For example, at a 20 MHz clock, 9600 baud with divisor 93, multiplier 5 and addend 2 lands within 0.0064 % of the target, where a plain divisor of 130 misses by 0.16 %.

Software programs the block through a small byte-wide register port. The two divisor bytes sit at offsets shared with other UART registers. They answer only while a latch-access bit in the control register is set; at other times their offsets belong to a different register outside this block. The fractional stretch comes from an accumulator. Each time the divisor expires without a stretch pending, the addend is added to the accumulator. When the sum reaches the multiplier, the multiplier is subtracted and one extra divisor period is inserted before the next pulse. A further divide-by-16 stage turns the oversampling pulse into a 1x bit-rate strobe.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the divisor is 0x0001, the multiplier is 1, the addend is 0 and the latch-access bit is 0. Reading offset 3 returns 0x10, and `tick16_o` is high in every cycle.
- R2: The register offsets are: 0 = divisor low byte, 1 = divisor high byte, 2 = control (bit 7 = latch-access), 3 = fraction (bits 7:4 multiplier, bits 3:0 addend). While the latch-access bit is 0, writes to offsets 0 and 1 are ignored and reads of them return 0x00.
- R3: When the multiplier is 0 or the addend is 0, every interval between successive `tick16_o` pulses is exactly `divisor` cycles.
- R4: When 0 < addend < multiplier, each interval is either `divisor` or `2*divisor` cycles. Any `multiplier` consecutive intervals add up to `divisor*(multiplier+addend)` cycles.
- R5: When the addend and multiplier are both non-zero and addend >= multiplier, every interval is `2*divisor` cycles.
- R6: A divisor of 0 produces no `tick16_o` pulses.
- R7: A write to offset 0 or 1 (while latch-access is 1) or to offset 3 restarts generation. The counter and accumulator clear, the pulse due in the cycle after the write edge is suppressed, and the first new pulse appears `divisor` cycles after the write edge.
- R8: With a divisor of 2 or more, `tick16_o` is high for a single cycle per pulse.
- R9: `tick1_o` pulses for one cycle, one cycle after every 16th `tick16_o` pulse counted from reset or restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| tick16_o | output | 1 | 16x oversampling enable pulse |
| tick1_o | output | 1 | 1x bit-rate strobe |

## Verification
A restart caused by a register write and the expiry of a divisor period can fall on the same clock edge. The bench provokes this with a divisor of 1, where every edge ends a period, and rewrites the low divisor byte. It expects exactly one pulse missing directly after the write edge and the pulse train resuming one cycle later. The other fractional and plain configurations, both directed and random, are judged against intervals and window sums that bench functions compute.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 2 * BYTE_W;
  localparam int FRAC_W = 4;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_DIVLO = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_DIVHI = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_FRAC  = 2'd3;

  localparam int CTRL_LATCH_BIT = 7;
endpackage

// File: rtl/frac_baud_regs.sv
module frac_baud_regs
  import frac_baud_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [DIV_W-1:0]  divisor,
  output logic [FRAC_W-1:0] mul,
  output logic [FRAC_W-1:0] addv,
  output logic              restart
);
  logic [BYTE_W-1:0] div_lo_q, div_lo_d;
  logic [BYTE_W-1:0] div_hi_q, div_hi_d;
  logic [FRAC_W-1:0] mul_q, mul_d;
  logic [FRAC_W-1:0] add_q, add_d;
  logic              latch_q, latch_d;
  logic              lo_we, hi_we, ctl_we, frac_we;

  always_comb begin
    lo_we   = wr && latch_q && (addr == ADR_DIVLO);
    hi_we   = wr && latch_q && (addr == ADR_DIVHI);
    ctl_we  = wr && (addr == ADR_CTRL);
    frac_we = wr && (addr == ADR_FRAC);
    div_lo_d = lo_we   ? wdata : div_lo_q;
    div_hi_d = hi_we   ? wdata : div_hi_q;
    latch_d  = ctl_we  ? wdata[CTRL_LATCH_BIT] : latch_q;
    mul_d    = frac_we ? wdata[2*FRAC_W-1:FRAC_W] : mul_q;
    add_d    = frac_we ? wdata[FRAC_W-1:0] : add_q;
    restart  = lo_we || hi_we || frac_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lo_q <= 8'h01;
      div_hi_q <= 8'h00;
      mul_q    <= 4'd1;
      add_q    <= 4'd0;
      latch_q  <= 1'b0;
    end else begin
      div_lo_q <= div_lo_d;
      div_hi_q <= div_hi_d;
      mul_q    <= mul_d;
      add_q    <= add_d;
      latch_q  <= latch_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_DIVLO: rdata = latch_q ? div_lo_q : '0;
      ADR_DIVHI: rdata = latch_q ? div_hi_q : '0;
      ADR_CTRL:  rdata = {latch_q, 7'd0};
      default:   rdata = {mul_q, add_q};
    endcase
  end

  assign divisor = {div_hi_q, div_lo_q};
  assign mul     = mul_q;
  assign addv    = add_q;

  AST_LOCKED_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !latch_q && addr == ADR_DIVLO) |=> $stable(div_lo_q)); // R2
  AST_LOCKED_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !latch_q && addr == ADR_DIVHI) |=> $stable(div_hi_q)); // R2
endmodule

// File: rtl/frac_baud_div.sv
module frac_baud_div
  import frac_baud_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [FRAC_W-1:0] mul,
  input  logic [FRAC_W-1:0] addv,
  input  logic              restart,
  output logic              tick
);
  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic              pend_q, pend_d;
  logic              tick_q, tick_d;
  logic              period_end, frac_on, frac_sat;
  logic [FRAC_W:0]   sum;

  always_comb begin
    period_end = (divisor != '0) && (cnt_q == divisor - 16'd1);
    frac_on    = (mul != '0) && (addv != '0);
    frac_sat   = frac_on && (addv >= mul);
    sum        = {1'b0, acc_q} + {1'b0, addv};
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    pend_d = pend_q;
    tick_d = 1'b0;
    if (restart) begin
      cnt_d  = '0;
      acc_d  = '0;
      pend_d = 1'b0;
    end else if (period_end) begin
      cnt_d = '0;
      if (pend_q) begin
        pend_d = 1'b0;
      end else begin
        tick_d = 1'b1;
        if (frac_sat) begin
          pend_d = 1'b1;
          acc_d  = '0;
        end else if (frac_on) begin
          if (sum >= {1'b0, mul}) begin
            acc_d  = FRAC_W'(sum - {1'b0, mul});
            pend_d = 1'b1;
          end else begin
            acc_d = sum[FRAC_W-1:0];
          end
        end
      end
    end else if (divisor != '0) begin
      cnt_d = cnt_q + 16'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      pend_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      pend_q <= pend_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_on && !frac_sat) |-> (acc_q < mul)); // R4
  AST_PLAIN_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!frac_on && $past(!frac_on) && !$past(restart)) |-> !pend_q); // R3
  AST_ZERO_DIV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(divisor == '0)) |-> !tick_q); // R6
  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0 && acc_q == '0 && !pend_q && !tick_q)); // R7
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && divisor > 16'd1 && $stable(divisor)) |=> !tick_q); // R8
endmodule

// File: rtl/frac_baud_bitdiv.sv
module frac_baud_bitdiv #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick16,
  output logic tick1
);
  localparam int PH_W = $clog2(OVS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            t1_q, t1_d;

  always_comb begin
    ph_d = ph_q;
    t1_d = 1'b0;
    if (restart) begin
      ph_d = '0;
    end else if (tick16) begin
      t1_d = (ph_q == PH_LAST);
      ph_d = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      t1_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      t1_q <= t1_d;
    end
  end

  assign tick1 = t1_q;

  AST_TICK1_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    tick1 |-> $past(tick16)); // R9
  AST_TICK1_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick1 |=> !tick1); // R9
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              tick16_o,
  output logic              tick1_o
);
  logic [DIV_W-1:0]  divisor;
  logic [FRAC_W-1:0] mul, addv;
  logic              restart;

  frac_baud_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .divisor(divisor), .mul(mul), .addv(addv), .restart(restart)
  );

  frac_baud_div u_div (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .mul(mul), .addv(addv),
    .restart(restart), .tick(tick16_o)
  );

  frac_baud_bitdiv #(.OVS(OVS)) u_bit (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick16(tick16_o), .tick1(tick1_o)
  );
endmodule

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       tick16_o, tick1_o;
  int checks = 0;
  int failures = 0;

  frac_baud_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick16_o(tick16_o), .tick1_o(tick1_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic cfg(input int dv, input int m, input int ad);
    wr_reg(2'd2, 8'h80);
    wr_reg(2'd0, 8'(dv));
    wr_reg(2'd1, 8'(dv >> 8));
    wr_reg(2'd3, {4'(m), 4'(ad)});
    wr_reg(2'd2, 8'h00);
  endtask

  task automatic next_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick16_o && n < 5000);
  endtask

  function automatic int plain_len(input int dv, input int m, input int ad);
    if (m == 0 || ad == 0) return dv;
    return 2 * dv;
  endfunction

  task automatic run_cfg(input int dv, input int m, input int ad, input string tag);
    int n, sum;
    cfg(dv, m, ad);
    next_tick(n);
    if (m != 0 && ad != 0 && ad < m) begin
      for (int w = 0; w < 2; w++) begin
        sum = 0;
        for (int i = 0; i < m; i++) begin
          next_tick(n);
          sum += n;
          if (n != dv && n != 2 * dv) chk(0, {tag, " R4 interval"}, n, dv);
        end
        chk(sum == dv * (m + ad), {tag, " R4 window"}, sum, dv * (m + ad));
      end
    end else begin
      for (int i = 0; i < 6; i++) begin
        next_tick(n);
        chk(n == plain_len(dv, m, ad), (m != 0 && ad != 0) ? {tag, " R5"} : {tag, " R3"},
            n, plain_len(dv, m, ad));
      end
    end
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n, cnt16, seen;
    void'($urandom(32'd20250));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd_reg(2'd3, d); chk(d == 8'h10, "R1 fraction", d, 8'h10);
    rd_reg(2'd2, d); chk(d == 8'h00, "R1 control", d, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk(tick16_o == 1'b1, "R1 tick every cycle", tick16_o, 1);
    end
    // R2 latch gating
    rd_reg(2'd0, d); chk(d == 8'h00, "R2 locked read", d, 0);
    wr_reg(2'd0, 8'h55);
    wr_reg(2'd2, 8'h80);
    rd_reg(2'd0, d); chk(d == 8'h01, "R2 write ignored lo", d, 1);
    rd_reg(2'd1, d); chk(d == 8'h00, "R2 hi value", d, 0);
    wr_reg(2'd2, 8'h00);

    // R3 / R4 directed vectors
    run_cfg(130, 0, 0, "plain130");
    run_cfg(93, 5, 2, "frac93");
    run_cfg(11, 0, 0, "plain11");
    run_cfg(4, 12, 7, "frac4");
    run_cfg(7, 0, 9, "mulzero");
    run_cfg(6, 3, 5, "sat");
    run_cfg(1, 15, 14, "div1frac");

    // random configurations
    for (int r = 0; r < 10; r++) begin
      run_cfg(1 + int'($urandom_range(0, 23)), int'($urandom_range(0, 15)),
              int'($urandom_range(0, 15)), "rand");
    end

    // R6 zero divisor
    cfg(0, 0, 0);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); if (tick16_o) seen++;
    end
    chk(seen == 0, "R6 no ticks", seen, 0);

    // R7 first pulse after restart
    cfg(5, 0, 0);
    wr_reg(2'd2, 8'h80);
    wr_reg(2'd0, 8'd5);
    n = 0;
    while (!tick16_o && n < 50) begin
      @(negedge clk); n++;
    end
    chk(n == 5, "R7 first pulse delay", n, 5);
    // R8 single cycle pulse
    @(negedge clk); chk(tick16_o == 1'b0, "R8 single cycle", tick16_o, 0);

    // R7 restart coinciding with a period end (divisor 1)
    wr_reg(2'd0, 8'd1);
    wr_reg(2'd1, 8'd0);
    repeat (3) @(negedge clk);
    chk(tick16_o == 1'b1, "R7 steady before", tick16_o, 1);
    wr_reg(2'd0, 8'd1);
    chk(tick16_o == 1'b0, "R7 suppressed pulse", tick16_o, 0);
    @(negedge clk);
    chk(tick16_o == 1'b1, "R7 resumed", tick16_o, 1);

    // R9 bit strobe after 16 oversampling pulses
    wr_reg(2'd0, 8'd2);
    cnt16 = 0; n = 0;
    while (!tick1_o && n < 200) begin
      @(negedge clk); n++;
      if (tick16_o) cnt16++;
    end
    chk(tick1_o == 1'b1, "R9 strobe seen", tick1_o, 1);
    chk(cnt16 == 16, "R9 pulses before strobe", cnt16, 16);
    cnt16 = 0; n = 0;
    do begin
      @(negedge clk); n++;
      if (tick16_o) cnt16++;
    end while (!tick1_o && n < 200);
    chk(n == 32, "R9 strobe period", n, 32);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule